// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Memory Write-Cycle Controller

This block is the digital control side of a byte-wide non-volatile memory with 2,048 locations of 8 bits. The storage is a register file inside the block. A host writes a byte by raising the write request while the chip is selected and the read request is low. The block captures the address and data on that edge and then runs a self-timed sequence on its own. The sequence first clears the target location to all ones and then programs it with the captured byte. The sequence lasts `WRITE_CYCLES` clocks; the default stands for a 10 ms worst case at 250 MHz.

While the sequence runs, the host can learn that the block is busy in two ways. It can watch the `ready` output, or it can poll with reads. A read taken during the sequence returns a status byte instead of stored data. The top bit of that status byte is the complement of the captured data's top bit. Once programming is done, a read returns the true byte. A high `protect` input or a high `supply_low` input at the strobe edge stops the sequence from starting.

The host port is a plain level-sampled memory bus, so it has no valid/ready pair. Back-pressure is expressed only by `ready`: a strobe that arrives while `ready` is low is dropped, and the host must wait.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: After reset `ready` is 1, and `rdata` is 0 whenever `sel` is low or `rd_req` is low.
- R2: A write starts on the first clock where `sel`=1, `wr_req`=1 and `rd_req`=0 after a clock where that condition was false. If neither blocking input is high and `ready` is 1, `ready` reads 0 after that same edge.
- R3: Address and data are captured at the starting edge. Later changes of `addr` or `wdata` do not affect which location is written or what value is stored.
- R4: `ready` stays 0 for exactly `WRITE_CYCLES` clock cycles and then returns to 1.
- R5: A read during the busy period (`sel`=1, `rd_req`=1, `wr_req`=0) returns a status byte. Bit 7 of that byte is the inverse of the captured data bit 7, and bits 6..0 are 0.
- R6: When the cycle ends, a read of the written address returns the new byte. This holds whatever the location held before, because the location is cleared to 8'hFF before it is programmed.
- R7: A strobe while `protect`=1 starts no cycle. `ready` stays 1 and the location keeps its old contents.
- R8: A strobe while `supply_low`=1 starts no cycle. `ready` stays 1 and the location keeps its old contents.
- R9: Strobes during the busy period are ignored. They neither lengthen the cycle nor change the captured address or data.
- R10: A strobe with `rd_req`=1 or with `sel`=0 starts no cycle.
- R11: Holding `wr_req` high past the end of a cycle does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select, active high |
| wr_req | input | 1 | Write request, active high; its qualified rising edge starts a write |
| rd_req | input | 1 | Read request, active high |
| addr | input | 11 | Byte address |
| wdata | input | 8 | Write data |
| protect | input | 1 | Hardware write protect, active high |
| supply_low | input | 1 | Supply below the safe write level, active high |
| rdata | output | 8 | Read data, or the status byte while busy |
| ready | output | 1 | 1 = idle, 0 = self-timed write in progress |

## Verification
A wrong internal state shows up at the ports in a few ways. A timer that is off by one or stuck makes `ready` stay low too long or too briefly, and the bench measures that to the exact cycle. A captured byte that was corrupted or overwritten shows up in the status bit 7 read on the very first poll after the strobe, and again in the read-back right after `ready` rises. A missing clear phase, or a blocked write that leaked through, leaves a wrong stored byte. The bench sees that on the next read of the address, within one cycle of the sequence ending.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLEAR = 2'd1,
    PH_PROG  = 2'd2
  } phase_t;
endpackage

// File: rtl/nvm_strobe_qual.sv
module nvm_strobe_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic wr_req,
  input  logic rd_req,
  output logic strobe_rise
);
  logic qual, qual_q;

  assign qual        = sel & wr_req & ~rd_req;
  assign strobe_rise = qual & ~qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual;
  end

  // R11
  strobe_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !strobe_rise);
endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer
  import nvm_pkg::*;
#(
  parameter int WRITE_CYCLES = 2_500_000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   clr_pulse,
  output logic   prog_pulse
);
  localparam int CLR_CYCLES = (WRITE_CYCLES >= 4) ? WRITE_CYCLES / 2 : 1;
  localparam int CNT_W      = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;

  logic [CNT_W-1:0] cnt;

  assign clr_pulse  = (phase == PH_CLEAR) && (cnt == CNT_W'(CLR_CYCLES - 1));
  assign prog_pulse = (phase == PH_PROG)  && (cnt == CNT_W'(WRITE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_CLEAR;
            cnt   <= '0;
          end
        end
        PH_CLEAR: begin
          cnt <= cnt + 1'b1;
          if (clr_pulse) phase <= PH_PROG;
        end
        PH_PROG: begin
          if (prog_pulse) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4
  timer_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |=> (phase == PH_IDLE));

  // R6
  clear_before_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (phase == PH_PROG));

  // R2
  start_enters_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase == PH_IDLE) |=> (phase == PH_CLEAR));
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdat,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdat
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdat;
  end

  assign rdat = mem[raddr];
endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 2_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              protect,
  input  logic              supply_low,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic              strobe, blocked, accept;
  logic              clr_pulse, prog_pulse, arr_we;
  phase_t            phase;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data, arr_wdat, arr_rdat;

  nvm_strobe_qual u_qual (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_req(wr_req), .rd_req(rd_req),
    .strobe_rise(strobe)
  );

  assign blocked = protect | supply_low;
  assign accept  = strobe & ready & ~blocked;

  nvm_wr_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .phase(phase),
    .clr_pulse(clr_pulse), .prog_pulse(prog_pulse)
  );

  assign ready = (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_data <= '0;
    end else if (accept) begin
      lat_addr <= addr;
      lat_data <= wdata;
    end
  end

  assign arr_we   = clr_pulse | prog_pulse;
  assign arr_wdat = clr_pulse ? ERASED : lat_data;

  nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(lat_addr), .wdat(arr_wdat),
    .raddr(addr), .rdat(arr_rdat)
  );

  always_comb begin
    rdata = '0;
    if (sel && rd_req && !wr_req) begin
      if (ready) rdata = arr_rdat;
      else       rdata = {~lat_data[DATA_W-1], {(DATA_W-1){1'b0}}};
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R7
  protect_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ready && protect) |=> ready);

  // R8
  supply_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ready && supply_low) |=> ready);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(lat_addr) && $stable(lat_data)));

  // R6
  array_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !ready);
endmodule

// File: tb/nvm_byte_ctrl_tb_top.sv
module nvm_byte_ctrl_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int W  = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          protect = 1'b0, supply_low = 1'b0;
  logic [DW-1:0] rdata;
  logic          ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nvm_byte_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_req(wr_req), .rd_req(rd_req),
    .addr(addr), .wdata(wdata), .protect(protect), .supply_low(supply_low),
    .rdata(rdata), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    sel = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
  endtask

  // one-cycle write strobe; returns at the negedge after the sampling edge
  task automatic strobe_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit hold);
    @(negedge clk);
    sel = 1'b1; rd_req = 1'b0; wr_req = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    addr = ~a; wdata = ~d;
    if (!hold) wr_req = 1'b0;
  endtask

  task automatic read_at(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    sel = 1'b1; wr_req = 1'b0; rd_req = 1'b1; addr = a;
    #1 v = rdata;
    rd_req = 1'b0; sel = 1'b0;
  endtask

  // counts negedges with ready low, starting at the current one
  task automatic count_busy(output int n);
    n = 0;
    while (ready == 1'b0 && n < 10 * W) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    #1;
    check(ready == 1'b1, "R1 ready after reset", ready, 1);
    check(rdata == '0, "R1 rdata idle", rdata, 0);
    @(negedge clk);
    sel = 1'b1; rd_req = 1'b0;
    #1 check(rdata == '0, "R1 rdata without rd_req", rdata, 0);
    idle_bus();
    v = '0;
  endtask

  task automatic t_write_ready_poll();
    int n;
    logic [DW-1:0] v;
    strobe_write(11'h123, 8'h5A, 1'b0);
    check(ready == 1'b0, "R2 ready falls after strobe", ready, 0);
    idle_bus();
    count_busy(n);
    check(n == W, "R4 busy length", n, W);
    read_at(11'h123, v);
    check(v == 8'h5A, "R3 R6 readback after bus changed", v, 8'h5A);
  endtask

  task automatic t_write_data_poll();
    logic [DW-1:0] v;
    int n;
    strobe_write(11'h7FF, 8'hC3, 1'b0);
    sel = 1'b1; wr_req = 1'b0; rd_req = 1'b1; addr = 11'h7FF;
    #1 check(rdata == 8'h00, "R5 first poll status", rdata, 8'h00);
    n = 0;
    while (rdata[7] != 1'b1 && n < 10 * W) begin
      @(negedge clk);
      #1 n++;
    end
    check(n == W, "R5 poll length", n, W);
    check(ready == 1'b1, "R5 ready agrees with poll", ready, 1);
    check(rdata == 8'hC3, "R6 poll final value", rdata, 8'hC3);
    idle_bus();
  endtask

  task automatic t_overwrite();
    int n;
    logic [DW-1:0] v;
    strobe_write(11'h7FF, 8'h00, 1'b0);
    sel = 1'b1; rd_req = 1'b1; addr = 11'h7FF;
    #1 check(rdata == 8'h80, "R5 status for bit7 zero", rdata, 8'h80);
    idle_bus();
    count_busy(n);
    read_at(11'h7FF, v);
    check(v == 8'h00, "R6 overwrite clears old bits", v, 8'h00);
  endtask

  task automatic t_blocked(input bit use_protect, input string req);
    logic [DW-1:0] v;
    protect = use_protect; supply_low = ~use_protect;
    strobe_write(11'h123, 8'hFF, 1'b0);
    idle_bus();
    repeat (3) begin
      @(negedge clk);
      check(ready == 1'b1, req, ready, 1);
    end
    protect = 1'b0; supply_low = 1'b0;
    repeat (W + 2) @(negedge clk);
    read_at(11'h123, v);
    check(v == 8'h5A, req, v, 8'h5A);
  endtask

  task automatic t_strobe_while_busy();
    int n;
    logic [DW-1:0] v;
    strobe_write(11'h010, 8'h11, 1'b0);
    idle_bus();
    n = 1;
    repeat (5) begin @(negedge clk); n++; end
    sel = 1'b1; wr_req = 1'b1; addr = 11'h123; wdata = 8'h99;
    @(negedge clk); n++;
    wr_req = 1'b0; rd_req = 1'b1; addr = 11'h010;
    #1 check(rdata == 8'h80, "R9 status keeps captured data", rdata, 8'h80);
    idle_bus();
    while (ready == 1'b0 && n < 10 * W) begin
      @(negedge clk); n++;
    end
    check(n == W + 1, "R9 busy not extended", n - 1, W);
    read_at(11'h010, v);
    check(v == 8'h11, "R9 first write stored", v, 8'h11);
    read_at(11'h123, v);
    check(v == 8'h5A, "R9 ignored write left old data", v, 8'h5A);
  endtask

  task automatic t_unqualified();
    logic [DW-1:0] v;
    @(negedge clk);
    sel = 1'b1; rd_req = 1'b1; wr_req = 1'b1; addr = 11'h123; wdata = 8'h01;
    @(negedge clk);
    check(ready == 1'b1, "R10 rd_req blocks start", ready, 1);
    idle_bus();
    @(negedge clk);
    sel = 1'b0; wr_req = 1'b1; addr = 11'h123; wdata = 8'h02;
    @(negedge clk);
    check(ready == 1'b1, "R10 sel low blocks start", ready, 1);
    idle_bus();
    read_at(11'h123, v);
    check(v == 8'h5A, "R10 contents unchanged", v, 8'h5A);
  endtask

  task automatic t_hold_strobe();
    int n;
    logic [DW-1:0] v;
    strobe_write(11'h055, 8'h3C, 1'b1);
    count_busy(n);
    check(n == W, "R11 single cycle length", n, W);
    repeat (5) begin
      @(negedge clk);
      check(ready == 1'b1, "R11 no retrigger while held", ready, 1);
    end
    idle_bus();
    read_at(11'h055, v);
    check(v == 8'h3C, "R11 stored value", v, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_ready_poll();
    t_write_data_poll();
    t_overwrite();
    t_blocked(1'b1, "R7 protect blocks write");
    t_blocked(1'b0, "R8 supply_low blocks write");
    t_strobe_while_busy();
    t_unqualified();
    t_hold_strobe();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule